// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the raw contents of a configuration-space device's base address registers into decode windows that address-matching logic downstream can use directly. It handles `NBAR` ordinary regions plus one expansion-ROM region. Each region supplies three things: its raw register value, its size as a power of two, and, for ordinary regions, whether it lives in I/O space or memory space. The two enable bits of the command register gate the two address spaces.

Whenever configuration logic writes the command register or any base register, it pulses `eval_i`. The block then recomputes every window at once. A window that fails any check is suppressed as a whole. It reports not-valid with base and last address forced to all ones. Each region also raises a one-cycle change pulse when its effective base moves, so the consumer can tear down the old mapping and install the new one.

Top module: `bar_window_decode`

## Requirements
- R1: While reset is asserted and after it is released, every window reads not-valid with base and last equal to all ones, and no change pulse is raised until the first evaluation.
- R2: A region whose size is zero or not a power of two never yields a valid window.
- R3: An I/O region can be valid only if `cmd_i` bit 0 was set at evaluation. A memory region or the ROM region can be valid only if `cmd_i` bit 1 was set.
- R4: For a valid window, the base equals the raw value with its low log2(size) bits cleared, and the last address equals base + size − 1. Low type bits in the raw value do not affect the base.
- R5: A window is invalid when its base is zero, or when its last address is not strictly above its base (wrap past the top of the address space, or size one).
- R6: An I/O window whose last address is at or above `IO_SPAN` (default 0x10000) is invalid. A memory or ROM window whose last address is all ones is invalid.
- R7: The ROM region (window index `NBAR`) can be valid only if bit 0 of `rom_raw_i` was set at evaluation.
- R8: An invalid window is reported with its valid bit at 0 and its base and last address at all ones.
- R9: Window outputs change only in the cycle after `eval_i` is sampled high. Input changes without `eval_i` have no effect on them.
- R10: A region's change pulse is high for exactly the one cycle after an evaluation, and only if that evaluation changed the region's effective base (the all-ones value counting as the base of an invalid window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Re-evaluate all windows (after a command or base register write) |
| cmd_i | input | 2 | Bit 0 enables I/O decoding, bit 1 enables memory decoding |
| bar_raw_i | input | NBAR*AW | Raw base register values, region n in bits [n*AW +: AW] |
| bar_size_i | input | NBAR*AW | Region sizes in bytes, region n in bits [n*AW +: AW] |
| bar_io_i | input | NBAR | Bit n set: region n is in I/O space |
| rom_raw_i | input | AW | Raw expansion-ROM register, bit 0 is the ROM enable |
| rom_size_i | input | AW | Expansion-ROM size in bytes |
| win_valid_o | output | NBAR+1 | Window valid, index NBAR is the ROM |
| win_base_o | output | (NBAR+1)*AW | Window base addresses |
| win_last_o | output | (NBAR+1)*AW | Window last addresses |
| win_chg_o | output | NBAR+1 | One-cycle pulse: effective base changed |

## Verification
The bench builds the block with its defaults: six ordinary regions, 32-bit addresses and a 64 KiB I/O space. With a 32-bit address, the all-ones top of memory and wrap-around past it can be reached with real register values. The I/O limit sits well inside the address range, so windows that end just below 0x10000 and just above it can both be placed. The ROM then sits at index 6, which lets the bench exercise its enable bit alongside six independent ordinary regions.

// File: rtl/bar_window_decode.sv
module bar_window_decode #(
  parameter int          NBAR    = 6,
  parameter int          AW      = 32,
  parameter int unsigned IO_SPAN = 65536
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eval_i,
  input  logic [1:0]               cmd_i,
  input  logic [NBAR*AW-1:0]       bar_raw_i,
  input  logic [NBAR*AW-1:0]       bar_size_i,
  input  logic [NBAR-1:0]          bar_io_i,
  input  logic [AW-1:0]            rom_raw_i,
  input  logic [AW-1:0]            rom_size_i,
  output logic [NBAR:0]            win_valid_o,
  output logic [(NBAR+1)*AW-1:0]   win_base_o,
  output logic [(NBAR+1)*AW-1:0]   win_last_o,
  output logic [NBAR:0]            win_chg_o
);
  localparam int             NREG   = NBAR + 1;
  localparam logic [AW:0]    IO_TOP = (AW+1)'(IO_SPAN);
  localparam logic [AW-1:0]  ONE    = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0]  ONES   = '1;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam bit IS_ROM = (r == NBAR);
    logic [AW-1:0] raw, sz, mask, base, last, eff_b, eff_l;
    logic          io, pow2, en, rom_ok, range_ok, ok;
    logic          v_q, c_q;
    logic [AW-1:0] b_q, l_q;

    if (IS_ROM) begin : g_rom
      assign raw = rom_raw_i;
      assign sz  = rom_size_i;
      assign io  = 1'b0;
    end else begin : g_bar
      assign raw = bar_raw_i[r*AW +: AW];
      assign sz  = bar_size_i[r*AW +: AW];
      assign io  = bar_io_i[r];
    end

    assign mask     = sz - ONE;
    assign pow2     = (sz != '0) && ((sz & mask) == '0);
    assign base     = raw & ~mask;
    assign last     = base + mask;
    assign en       = io ? cmd_i[0] : cmd_i[1];
    assign rom_ok   = !IS_ROM || raw[0];
    assign range_ok = io ? ({1'b0, last} < IO_TOP) : (last != ONES);
    assign ok       = pow2 && en && rom_ok && (last > base) && (base != '0) && range_ok;
    assign eff_b    = ok ? base : ONES;
    assign eff_l    = ok ? last : ONES;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        b_q <= ONES;
        l_q <= ONES;
        c_q <= 1'b0;
      end else begin
        c_q <= 1'b0;
        if (eval_i) begin
          v_q <= ok;
          b_q <= eff_b;
          l_q <= eff_l;
          c_q <= (eff_b != b_q);
        end
      end
    end

    assign win_valid_o[r]          = v_q;
    assign win_base_o[r*AW +: AW]  = b_q;
    assign win_last_o[r*AW +: AW]  = l_q;
    assign win_chg_o[r]            = c_q;
  end
endmodule

// File: rtl/bar_window_decode_chk.sv
module bar_window_decode_chk #(
  parameter int NBAR = 6,
  parameter int AW   = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   eval_i,
  input logic [1:0]             cmd_i,
  input logic                   rom_en_i,
  input logic [NBAR:0]          win_valid_o,
  input logic [(NBAR+1)*AW-1:0] win_base_o,
  input logic [(NBAR+1)*AW-1:0] win_last_o,
  input logic [NBAR:0]          win_chg_o
);
  for (genvar r = 0; r <= NBAR; r++) begin : g_a
    AST_INVALID_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid_o[r] |-> (win_base_o[r*AW +: AW] == '1) && (win_last_o[r*AW +: AW] == '1)); // R8
    AST_VALID_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o[r] |-> (win_last_o[r*AW +: AW] > win_base_o[r*AW +: AW]) && (win_base_o[r*AW +: AW] != '0)); // R5
    AST_CHG_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
      win_chg_o[r] |-> $past(eval_i)); // R10
    AST_HOLD_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eval_i) |-> $stable(win_base_o[r*AW +: AW]) && $stable(win_valid_o[r])); // R9
  end
  AST_ROM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eval_i) && !$past(rom_en_i) |-> !win_valid_o[NBAR]); // R7
  AST_ROM_MEM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eval_i) && !$past(cmd_i[1]) |-> !win_valid_o[NBAR]); // R3
endmodule

bind bar_window_decode bar_window_decode_chk #(.NBAR(NBAR), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .cmd_i(cmd_i), .rom_en_i(rom_raw_i[0]),
  .win_valid_o(win_valid_o), .win_base_o(win_base_o), .win_last_o(win_last_o),
  .win_chg_o(win_chg_o)
);

// File: tb/bar_window_decode_tb_top.sv
module bar_window_decode_tb_top;
  localparam int NBAR = 6, AW = 32, NREG = NBAR + 1;
  localparam longint unsigned TOPA = 64'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, eval = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [AW-1:0] raw [NREG];
  logic [AW-1:0] sz  [NREG];
  logic [NBAR-1:0] io = '0;
  logic [NBAR*AW-1:0] bar_raw, bar_size;
  logic [NREG-1:0] v_o, c_o;
  logic [NREG*AW-1:0] b_o, l_o;
  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  always_comb for (int r = 0; r < NBAR; r++) begin
    bar_raw[r*AW +: AW]  = raw[r];
    bar_size[r*AW +: AW] = sz[r];
  end

  bar_window_decode dut_i (
    .clk(clk), .rst_n(rst_n), .eval_i(eval), .cmd_i(cmd),
    .bar_raw_i(bar_raw), .bar_size_i(bar_size), .bar_io_i(io),
    .rom_raw_i(raw[NBAR]), .rom_size_i(sz[NBAR]),
    .win_valid_o(v_o), .win_base_o(b_o), .win_last_o(l_o), .win_chg_o(c_o));

  bit mv [NREG];
  bit mc [NREG];
  longint unsigned mb [NREG], ml [NREG];

  function automatic void ref_win(int r, output bit v, output longint unsigned b, output longint unsigned l);
    longint unsigned s = sz[r], x = raw[r];
    bit is_io = (r < NBAR) ? io[r] : 1'b0;
    v = 1;
    if (s == 0 || (s & (s - 1)) != 0) v = 0;
    else begin
      b = x - (x % s);
      l = b + s - 1;
      if (l > TOPA || l == b || b == 0) v = 0;
      if (is_io && (!cmd[0] || l >= 64'h10000)) v = 0;
      if (!is_io && (!cmd[1] || l == TOPA)) v = 0;
      if (r == NBAR && !raw[r][0]) v = 0;
    end
    if (!v) begin b = TOPA; l = TOPA; end
  endfunction

  always @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      bit v; longint unsigned b, l;
      if (!rst_n) begin mv[r] = 0; mb[r] = TOPA; ml[r] = TOPA; mc[r] = 0; end
      else begin
        mc[r] = 0;
        if (eval) begin
          ref_win(r, v, b, l);
          mc[r] = (b != mb[r]);
          mv[r] = v; mb[r] = b; ml[r] = l;
        end
      end
    end
  end

  always @(negedge clk) if (started && rst_n) begin
    bit bad = 0;
    checks++;
    for (int r = 0; r < NREG; r++)
      if (v_o[r] != mv[r] || c_o[r] != mc[r] || b_o[r*AW +: AW] != mb[r][31:0] || l_o[r*AW +: AW] != ml[r][31:0]) begin
        bad = 1;
        $display("FAIL model R4/R10 win %0d: act v=%0b c=%0b b=%h l=%h exp v=%0b c=%0b b=%h l=%h", r,
          v_o[r], c_o[r], b_o[r*AW +: AW], l_o[r*AW +: AW], mv[r], mc[r], mb[r][31:0], ml[r][31:0]);
      end
    if (bad) fails++;
  end

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_eval();
    eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin raw[r] = '0; sz[r] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", v_o, 0);
    chk("R1 base in reset", b_o[31:0], TOPA);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    chk("R1 valid after reset", v_o, 0);
    chk("R1 chg after reset", c_o, 0);

    cmd = 2'b10; raw[0] = 32'h8000_1234; sz[0] = 32'h1000;
    do_eval();
    chk("R4 base", b_o[31:0], 32'h8000_1000);
    chk("R4 last", l_o[31:0], 32'h8000_1FFF);
    chk("R10 chg on move", c_o[0], 1);
    @(negedge clk);
    chk("R10 pulse width", c_o[0], 0);
    do_eval();
    chk("R10 no chg same base", c_o[0], 0);

    io[1] = 1; raw[1] = 32'h0000_C0E1; sz[1] = 32'h20;
    do_eval();
    chk("R3 io gated off", v_o[1], 0);
    chk("R8 invalid base ones", b_o[AW +: AW], TOPA);
    cmd = 2'b01;
    do_eval();
    chk("R3 io enabled", v_o[1], 1);
    chk("R4 io base", b_o[AW +: AW], 32'hC0E0);
    chk("R3 mem gated off", v_o[0], 0);
    cmd = 2'b11;
    raw[1] = 32'h0000_FFF1;
    do_eval();
    chk("R6 io ends at limit-1", l_o[AW +: AW], 32'hFFFF);
    raw[1] = 32'h0001_0001;
    do_eval();
    chk("R6 io beyond limit", v_o[1], 0);

    raw[2] = 32'hFFFF_F000; sz[2] = 32'h1000;
    do_eval();
    chk("R6 mem last all ones", v_o[2], 0);
    raw[2] = 32'h0000_0ABC;
    do_eval();
    chk("R5 zero base", v_o[2], 0);
    raw[2] = 32'h0000_0100; sz[2] = 32'h1;
    do_eval();
    chk("R5 size one no span", v_o[2], 0);
    raw[3] = 32'h4000_0000; sz[3] = 32'h3000;
    do_eval();
    chk("R2 non power of two", v_o[3], 0);
    sz[3] = 0;
    do_eval();
    chk("R2 size zero", v_o[3], 0);

    raw[NBAR] = 32'hC000_0000; sz[NBAR] = 32'h1_0000;
    do_eval();
    chk("R7 rom disabled", v_o[NBAR], 0);
    raw[NBAR] = 32'hC000_0001;
    do_eval();
    chk("R7 rom enabled", v_o[NBAR], 1);
    chk("R7 rom base", b_o[NBAR*AW +: AW], 32'hC000_0000);

    raw[0] = 32'h9000_0000; cmd = 2'b00;
    repeat (3) @(negedge clk);
    chk("R9 hold without eval", b_o[31:0], 32'h8000_1000);
    chk("R9 no pulse without eval", c_o, 0);

    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, NREG - 1);
      int k = $urandom_range(0, 35);
      raw[r] = (k % 3 == 0) ? 32'hFFFF_FFFF - $urandom_range(0, 70000) : $urandom;
      if (k % 5 == 0) raw[r] = $urandom_range(0, 131071);
      sz[r] = (k < 32) ? (32'h1 << k) : ((k == 32) ? 32'h0 : $urandom);
      if (r < NBAR) io[r] = $urandom_range(0, 1);
      cmd = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) != 0) do_eval(); else @(negedge clk);
    end
    done = 1;
    finish_run();
  end
endmodule